// File: doc/BRIEF.md
# Register Dependence Latency Scoreboard

This block decides, in the same cycle that a request is presented, whether one candidate instruction may issue without breaking a data-dependence delay. For every architectural register it keeps the class of the last instruction that wrote it and the number of cycles since that write. From these it works out the cost of each dependence the candidate has on earlier instructions. If any cost is not yet covered, it raises a stall. When there is no stall, the candidate's destination register takes the new class and its age restarts.

The cost of a dependence depends on its kind. A read of a pending result waits for the producer's latency. A write that follows another write waits for the amount by which the producer's latency exceeds the consumer's. A write that follows a read costs nothing.

The latency of a read can be replaced by an entry in an ordered bypass table, keyed on the producer and consumer classes. An entry may carry a guard, which is true only when the consumer reads that operand as an address. Among the matching entries, the first guarded entry whose guard is true wins. If none is true, the unguarded entry applies. If no entry matches, the producer's own latency applies.

Top module: `sb_latency_scoreboard`

## Requirements
- R1: Class codes are integer 0, multiply 1, divide 2 and floating point 3. After reset every register is ready, so the first request issues whatever registers it names.
- R2: A consumer that reads the result of a producer may issue L cycles after the producer issued, and not earlier. L is 2 for integer, 4 for multiply, 9 for divide and 3 for floating point, unless a bypass in R5 or R6 applies.
- R3: A write-after-read dependence costs zero cycles: an instruction that writes a register read by the instruction issued one cycle earlier issues at once.
- R4: A write-after-write dependence delays the second writer by the producer latency minus the consumer latency, with a negative difference clamped to zero. Both latencies are the base values of R2.
- R5: A floating point result read by an integer, multiply or divide consumer has latency 4. A floating point result read by a floating point consumer keeps latency 3.
- R6: A source operand is flagged as an address when its role bit is 1. The guarded bypass entries apply only to flagged operands of an integer consumer. A floating point producer then costs 5 cycles, an integer producer 1 cycle, and a multiply producer 3 cycles. The multiply case has two guarded entries, for 3 and 2 cycles, and the first in table order wins. An operand that is not flagged uses R2 or R5.
- R7: Register 0 is always ready and is never written. A source or destination of 0 never causes a stall.
- R8: A request that stalls leaves every register's state unchanged.
- R9: issue_o is high exactly when req_valid is high and stall_o is low. With req_valid low, stall_o is low.
- R10: A new write to a register replaces its previous class and age. Later readers are timed from the newest write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A candidate instruction is presented this cycle |
| req_cls | input | 2 | Class of the candidate (0 int, 1 mul, 2 div, 3 fp) |
| req_dst | input | 4 | Destination register, 0 for none |
| req_src_a | input | 4 | First source register, 0 for none |
| req_src_b | input | 4 | Second source register, 0 for none |
| req_a_is_addr | input | 1 | First source is read as an address |
| req_b_is_addr | input | 1 | Second source is read as an address |
| stall_o | output | 1 | Candidate must not issue this cycle |
| issue_o | output | 1 | Candidate issues this cycle and updates state |

## Verification
Producer and consumer pairs are issued back to back, and the cycle in which the consumer finally issues is measured. This separates the base latencies of each class from the plain floating point bypass, and separates both from the address-guarded bypasses, including the pair where two guarded entries compete. Pairs with a shared destination and with a destination equal to an earlier source separate the clamped write-after-write cost from the free write-after-read case. A stalled write that is abandoned, a register rewritten before it is read, and long pseudo-random request streams show whether state changes only on issue and whether the newest write sets the timing.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int LAT_W   = 4;
    localparam int NSRC    = 2;
    localparam int NBYPASS = 5;

    typedef logic [LAT_W-1:0] lat_t;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_MUL = 2'd1,
        CLS_DIV = 2'd2,
        CLS_FP  = 2'd3
    } icls_e;

    typedef struct packed {
        icls_e      prod;
        logic [3:0] cons_mask;  // bit index = consumer class code
        logic       guarded;    // applies only to address operands
        lat_t       lat;
    } bypass_t;

    function automatic lat_t base_lat(icls_e c);
        case (c)
            CLS_INT: return lat_t'(2);
            CLS_MUL: return lat_t'(4);
            CLS_DIV: return lat_t'(9);
            default: return lat_t'(3);
        endcase
    endfunction

    // Ordered bypass table; order matters for guarded entries.
    function automatic bypass_t bp_entry(int idx);
        bypass_t e;
        case (idx)
            0:       e = '{prod: CLS_FP,  cons_mask: 4'b0001, guarded: 1'b1, lat: lat_t'(5)};
            1:       e = '{prod: CLS_FP,  cons_mask: 4'b0111, guarded: 1'b0, lat: lat_t'(4)};
            2:       e = '{prod: CLS_INT, cons_mask: 4'b0001, guarded: 1'b1, lat: lat_t'(1)};
            3:       e = '{prod: CLS_MUL, cons_mask: 4'b0001, guarded: 1'b1, lat: lat_t'(3)};
            default: e = '{prod: CLS_MUL, cons_mask: 4'b0001, guarded: 1'b1, lat: lat_t'(2)};
        endcase
        return e;
    endfunction

    function automatic lat_t raw_lat(icls_e p, icls_e c, logic is_addr);
        logic    g_hit;
        logic    u_hit;
        lat_t    g_lat;
        lat_t    u_lat;
        bypass_t e;
        g_hit = 1'b0;
        u_hit = 1'b0;
        g_lat = '0;
        u_lat = '0;
        for (int i = 0; i < NBYPASS; i++) begin
            e = bp_entry(i);
            if (e.prod == p && e.cons_mask[c]) begin
                if (e.guarded) begin
                    if (is_addr && !g_hit) begin
                        g_hit = 1'b1;
                        g_lat = e.lat;
                    end
                end else if (!u_hit) begin
                    u_hit = 1'b1;
                    u_lat = e.lat;
                end
            end
        end
        if (g_hit)      return g_lat;
        else if (u_hit) return u_lat;
        else            return base_lat(p);
    endfunction

    function automatic lat_t waw_lat(icls_e p, icls_e c);
        lat_t lp;
        lat_t lc;
        lp = base_lat(p);
        lc = base_lat(c);
        return (lp > lc) ? lat_t'(lp - lc) : lat_t'(0);
    endfunction

endpackage

// File: rtl/sb_age_file.sv
module sb_age_file
    import sb_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int AGE_W = 4,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  icls_e            wr_cls,
    output logic [AGE_W-1:0] age_q [NREG],
    output icls_e            cls_q [NREG]
);

    localparam logic [AGE_W-1:0] AGE_SAT = '1;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        if (r == 0) begin : g_zero
            assign age_q[r] = AGE_SAT;
            assign cls_q[r] = CLS_INT;
        end else begin : g_live
            logic [AGE_W-1:0] age_r;
            icls_e            cls_r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    age_r <= AGE_SAT;
                    cls_r <= CLS_INT;
                end else if (wr_en && wr_idx == REG_W'(r)) begin
                    age_r <= AGE_W'(1);
                    cls_r <= wr_cls;
                end else if (age_r != AGE_SAT) begin
                    age_r <= age_r + 1'b1;
                end
            end
            assign age_q[r] = age_r;
            assign cls_q[r] = cls_r;
        end
    end

    // R10
    age_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != '0) |=> (age_q[$past(wr_idx)] == AGE_W'(1)));

endmodule

// File: rtl/sb_raw_check.sv
module sb_raw_check
    import sb_pkg::*;
#(
    parameter int AGE_W = 4
) (
    input  logic             src_used,
    input  icls_e            prod_cls,
    input  logic [AGE_W-1:0] age,
    input  icls_e            cons_cls,
    input  logic             is_addr,
    output logic             hazard
);
    lat_t need;
    always_comb begin
        need   = raw_lat(prod_cls, cons_cls, is_addr);
        hazard = src_used && (age < AGE_W'(need));
    end
endmodule

// File: rtl/sb_waw_check.sv
module sb_waw_check
    import sb_pkg::*;
#(
    parameter int AGE_W = 4
) (
    input  logic             dst_used,
    input  icls_e            prod_cls,
    input  logic [AGE_W-1:0] age,
    input  icls_e            cons_cls,
    output logic             hazard
);
    lat_t need;
    always_comb begin
        need   = waw_lat(prod_cls, cons_cls);
        hazard = dst_used && (age < AGE_W'(need));
    end
endmodule

// File: rtl/sb_latency_scoreboard.sv
module sb_latency_scoreboard
    import sb_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int AGE_W = 4,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_cls,
    input  logic [REG_W-1:0] req_dst,
    input  logic [REG_W-1:0] req_src_a,
    input  logic [REG_W-1:0] req_src_b,
    input  logic             req_a_is_addr,
    input  logic             req_b_is_addr,
    output logic             stall_o,
    output logic             issue_o
);

    icls_e            cons;
    logic [AGE_W-1:0] age_q [NREG];
    icls_e            cls_q [NREG];
    logic [REG_W-1:0] src_idx  [NSRC];
    logic             src_addr [NSRC];
    logic [NSRC-1:0]  raw_hz;
    logic             waw_hz;

    assign cons        = icls_e'(req_cls);
    assign src_idx[0]  = req_src_a;
    assign src_idx[1]  = req_src_b;
    assign src_addr[0] = req_a_is_addr;
    assign src_addr[1] = req_b_is_addr;

    sb_age_file #(.NREG(NREG), .AGE_W(AGE_W)) u_ages (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (issue_o),
        .wr_idx (req_dst),
        .wr_cls (cons),
        .age_q  (age_q),
        .cls_q  (cls_q)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        sb_raw_check #(.AGE_W(AGE_W)) u_raw (
            .src_used (src_idx[s] != '0),
            .prod_cls (cls_q[src_idx[s]]),
            .age      (age_q[src_idx[s]]),
            .cons_cls (cons),
            .is_addr  (src_addr[s]),
            .hazard   (raw_hz[s])
        );
    end

    sb_waw_check #(.AGE_W(AGE_W)) u_waw (
        .dst_used (req_dst != '0),
        .prod_cls (cls_q[req_dst]),
        .age      (age_q[req_dst]),
        .cons_cls (cons),
        .hazard   (waw_hz)
    );

    assign stall_o = req_valid && ((|raw_hz) || waw_hz);
    assign issue_o = req_valid && !stall_o;

    // R7
    zero_reg_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_src_a == '0 && req_src_b == '0 && req_dst == '0) |-> !stall_o);

    // R2
    raw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(issue_o) && $past(req_cls) != 2'd0 && $past(req_dst) != '0
         && req_valid && req_src_a == $past(req_dst)) |-> stall_o);

    // R4
    waw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(issue_o) && $past(req_cls) == 2'd2 && $past(req_dst) != '0
         && req_valid && req_dst == $past(req_dst) && req_cls == 2'd0) |-> stall_o);

endmodule

// File: tb/tb_sb_latency_scoreboard.sv
`timescale 1ns/1ps
module tb_sb_latency_scoreboard;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_cls = 2'd0;
    logic [3:0] req_dst = 4'd0;
    logic [3:0] req_src_a = 4'd0;
    logic [3:0] req_src_b = 4'd0;
    logic       req_a_is_addr = 1'b0;
    logic       req_b_is_addr = 1'b0;
    logic       stall_o;
    logic       issue_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;
    bit last_issue;

    int age_m [16];
    int cls_m [16];

    always #10 clk = ~clk;

    sb_latency_scoreboard dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cls(req_cls),
        .req_dst(req_dst), .req_src_a(req_src_a), .req_src_b(req_src_b),
        .req_a_is_addr(req_a_is_addr), .req_b_is_addr(req_b_is_addr),
        .stall_o(stall_o), .issue_o(issue_o)
    );

    function automatic int lat_of(int c);
        case (c)
            0: return 2;
            1: return 4;
            2: return 9;
            default: return 3;
        endcase
    endfunction

    function automatic int raw_need(int p, int c, bit addr);
        if (p == 3 && c != 3) return (addr && c == 0) ? 5 : 4;
        if (p == 0 && c == 0 && addr) return 1;
        if (p == 1 && c == 0 && addr) return 3;
        return lat_of(p);
    endfunction

    function automatic int waw_need(int p, int c);
        int d;
        d = lat_of(p) - lat_of(c);
        return (d > 0) ? d : 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit v, input int c, input int d, input int sa, input int sb,
                        input bit aa, input bit ab, input string tag);
        bit es;
        bit ei;
        @(negedge clk);
        req_valid = v; req_cls = c[1:0]; req_dst = d[3:0];
        req_src_a = sa[3:0]; req_src_b = sb[3:0];
        req_a_is_addr = aa; req_b_is_addr = ab;
        #5;
        es = v && ((sa != 0 && age_m[sa] < raw_need(cls_m[sa], c, aa)) ||
                   (sb != 0 && age_m[sb] < raw_need(cls_m[sb], c, ab)) ||
                   (d != 0 && age_m[d] < waw_need(cls_m[d], c)));
        ei = v && !es;
        check(stall_o == es, {tag, " stall"}, int'(stall_o), int'(es));
        check(issue_o == ei, {tag, " issue"}, int'(issue_o), int'(ei));
        last_issue = issue_o;
        @(posedge clk);
        for (int r = 1; r < 16; r++) if (age_m[r] < 15) age_m[r]++;
        if (ei && d != 0) begin
            age_m[d] = 1;
            cls_m[d] = c;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step(0, 0, 0, 0, 0, 0, 0, "R9 idle");
            check(stall_o == 1'b0 && issue_o == 1'b0, "R9 idle outputs", int'(stall_o), 0);
        end
    endtask

    // Hold a consumer request until it issues; check cycles since producer.
    task automatic measure(input int c, input int d, input int sa, input int sb,
                           input bit aa, input bit ab, input int exp, input string tag);
        int k;
        k = 0;
        for (int i = 1; i <= 20; i++) begin
            step(1, c, d, sa, sb, aa, ab, tag);
            if (last_issue) begin
                k = i;
                break;
            end
        end
        check(k == exp, {tag, " delay"}, k, exp);
    endtask

    task automatic pair(input int p, input int pd, input int psa, input int c, input int cd,
                        input int csa, input int csb, input bit aa, input bit ab,
                        input int exp, input string tag);
        idle(12);
        step(1, p, pd, psa, 0, 0, 0, tag);
        check(last_issue == 1'b1, {tag, " producer"}, int'(last_issue), 1);
        measure(c, cd, csa, csb, aa, ab, exp, tag);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int r = 0; r < 16; r++) begin
            age_m[r] = 15;
            cls_m[r] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything ready after reset
        step(1, 2, 5, 7, 9, 0, 0, "R1 first request");
        check(last_issue == 1'b1, "R1 issue after reset", int'(last_issue), 1);

        // R2 base latencies
        pair(0, 3, 0, 0, 0, 3, 0, 0, 0, 2, "R2 int->int");
        pair(1, 3, 0, 1, 0, 3, 0, 0, 0, 4, "R2 mul->mul");
        pair(2, 3, 0, 2, 0, 0, 3, 0, 0, 9, "R2 div->div srcb");
        pair(3, 3, 0, 3, 0, 3, 0, 0, 0, 3, "R5 fp->fp");
        // R5 fp feeding integer classes
        pair(3, 4, 0, 0, 0, 4, 0, 0, 0, 4, "R5 fp->int");
        pair(3, 4, 0, 2, 0, 4, 0, 0, 0, 4, "R5 fp->div");
        pair(3, 4, 0, 1, 0, 4, 0, 1, 0, 4, "R6 fp->mul addr unguarded");
        // R6 guarded bypasses
        pair(3, 5, 0, 0, 0, 5, 0, 1, 0, 5, "R6 fp->int addr");
        pair(0, 5, 0, 0, 0, 5, 0, 1, 0, 1, "R6 int->int addr");
        pair(0, 5, 0, 0, 0, 0, 5, 0, 1, 1, "R6 int->int addr srcb");
        pair(1, 5, 0, 0, 0, 5, 0, 1, 0, 3, "R6 mul->int addr first entry");
        pair(1, 5, 0, 0, 0, 5, 0, 0, 0, 4, "R6 mul->int data");
        // R3 write after read
        pair(2, 4, 6, 0, 6, 0, 0, 0, 0, 1, "R3 war");
        // R4 write after write
        pair(2, 8, 0, 0, 8, 0, 0, 0, 0, 7, "R4 waw div-int");
        pair(0, 8, 0, 2, 8, 0, 0, 0, 0, 1, "R4 waw clamp");
        pair(3, 8, 0, 0, 8, 0, 0, 0, 0, 1, "R4 waw fp-int");
        pair(1, 8, 0, 0, 8, 0, 0, 0, 0, 2, "R4 waw mul-int");
        // R7 register zero
        pair(2, 0, 0, 3, 0, 0, 0, 0, 0, 1, "R7 zero dst");
        step(1, 0, 0, 0, 0, 0, 0, "R7 all zero");
        check(last_issue == 1'b1, "R7 all zero issue", int'(last_issue), 1);

        // R8 abandoned stalled write leaves state alone
        idle(12);
        step(1, 3, 5, 0, 0, 0, 0, "R8 producer");
        step(1, 0, 7, 5, 0, 0, 0, "R8 stalled write");
        check(last_issue == 1'b0, "R8 stalled", int'(last_issue), 0);
        step(1, 3, 0, 7, 0, 0, 0, "R8 read untouched reg");
        check(last_issue == 1'b1, "R8 reg unchanged", int'(last_issue), 1);

        // R10 rewrite retimes readers
        idle(12);
        step(1, 3, 9, 0, 0, 0, 0, "R10 fp write");
        step(1, 0, 9, 0, 0, 0, 0, "R10 int rewrite");
        check(last_issue == 1'b1, "R10 rewrite issued", int'(last_issue), 1);
        measure(0, 0, 9, 0, 0, 0, 2, "R10 newest timing");

        // R2/R4/R6 pseudo-random stream against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            int c, d, sa, sb;
            bit aa, ab;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c  = int'(lfsr[1:0]);
            d  = int'(lfsr[5:2]) & 7;
            sa = int'(lfsr[9:6]) & 7;
            sb = int'(lfsr[13:10]) & 7;
            aa = lfsr[14];
            ab = lfsr[15] ^ lfsr[0];
            step(lfsr[3] | lfsr[8], c, d, sa, sb, aa, ab, "R2 R4 R6 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule